// File: doc/BRIEF.md
# Memory Image CRC-8 Checker

This block verifies the integrity of a small nonvolatile memory image. It walks every byte address of the memory through a synchronous read port with a one-cycle read latency, in ascending order. It folds each data byte into a running CRC-8 and then compares the result with the reference checksum held in the top byte of the memory. The reads are pipelined, so one byte is consumed per clock.

A check has three possible triggers: the release of reset, a write to the top byte of the memory seen on the programming-observation inputs, and a one-cycle software request. A trigger that arrives while a check is running is remembered, and any number of such triggers produce a single further check after the current one. The block presents a busy flag, a pass flag and the last computed checksum, all registered.

Top module: `crc8_mem_checker`

## Requirements
- R1: While `rst` is high, `busy`, `crc_ok` and `rd_en` are 0 and `crc_value` is 0x00. A check starts on the first rising edge after `rst` falls, so `busy` is 1 after that edge.
- R2: The checksum starts at 0xFF and takes in the bytes at addresses 0 to DEPTH-2 in ascending order. Each step is one CRC-8 step of polynomial x^8+x^2+x+1, most significant bit first, with no reflection and no final inversion. The byte at DEPTH-1 is not folded in. The result appears on `crc_value` when the check ends.
- R3: After a check, `crc_ok` is 1 exactly when the computed checksum equals the byte read from address DEPTH-1, and is 0 otherwise. On a mismatch `crc_value` still shows the computed checksum.
- R4: Each check issues exactly DEPTH reads, one per cycle, at addresses 0 to DEPTH-1 in ascending order. `rd_en` is high only while `busy` is high, and `rd_data` is taken one cycle after its read. `busy` is high for exactly DEPTH+1 consecutive cycles.
- R5: A cycle with `prog_we`=1 and `prog_addr`=DEPTH-1 while the block is idle starts a check. If the write is sampled at edge k, `busy` is 1 after edge k+1. Writes to any other address start nothing.
- R6: A one-cycle `calc_req` pulse while the block is idle starts a check with the same timing as R5.
- R7: Triggers (R5, R6) that occur while `busy` is high are latched. Any number of them yield exactly one further check, which starts after `busy` has been low for exactly one cycle.
- R8: `crc_ok` is 0 whenever `busy` is 1. `crc_ok` and `crc_value` take their new values at the edge where `busy` falls and hold them until the next check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_we | input | 1 | A memory write is taking place this cycle |
| prog_addr | input | AW | Address of that memory write |
| calc_req | input | 1 | One-cycle software request for a check |
| rd_en | output | 1 | Read strobe to the memory |
| rd_addr | output | AW | Read address to the memory |
| rd_data | input | 8 | Read data, valid one cycle after `rd_en` |
| busy | output | 1 | A check is in progress |
| crc_ok | output | 1 | The last check matched the stored checksum |
| crc_value | output | 8 | Checksum computed by the last check |

## Verification
A trigger sampled at one edge shows up as `busy` one edge later. `busy` then stays high for DEPTH+1 cycles, and `crc_ok` and `crc_value` change at the edge where it falls. The bench drives inputs and samples outputs on the falling clock edge. It checks that `busy` is still low one sample after a trigger and high at the next sample, counts the high samples against DEPTH+1, and reads the results at the first sample where `busy` is low. For a rescan, `busy` must be low at exactly that one sample and high again at the next. A monitor on the read port counts the reads and checks the address order independently of the design.

// File: rtl/crc8_chk_pkg.sv
package crc8_chk_pkg;

  localparam logic [7:0] CRC_SEED = 8'hFF;

  // One byte step of CRC-8, polynomial 0x07, MSB first, written as a flat XOR network
  function automatic logic [7:0] crc8_fold(input logic [7:0] cur, input logic [7:0] dat);
    logic [7:0] x;
    logic [7:0] n;
    x    = cur ^ dat;
    n[0] = x[0] ^ x[6] ^ x[7];
    n[1] = x[0] ^ x[1] ^ x[6];
    n[2] = x[0] ^ x[1] ^ x[2] ^ x[6];
    n[3] = x[1] ^ x[2] ^ x[3] ^ x[7];
    n[4] = x[2] ^ x[3] ^ x[4];
    n[5] = x[3] ^ x[4] ^ x[5];
    n[6] = x[4] ^ x[5] ^ x[6];
    n[7] = x[5] ^ x[6] ^ x[7];
    return n;
  endfunction

endpackage

// File: rtl/crc8_trig.sv
module crc8_trig #(
  parameter int DEPTH = 128,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          busy,
  input  logic          calc_req,
  input  logic          prog_we,
  input  logic [AW-1:0] prog_addr,
  output logic          start
);

  localparam logic [AW-1:0] TOP_ADDR = AW'(DEPTH - 1);

  logic pend_q;
  logic hit;

  assign hit   = calc_req | (prog_we && (prog_addr == TOP_ADDR));
  assign start = pend_q & ~busy;

  // Reset leaves a request pending, so a check follows reset release.
  always_ff @(posedge clk) begin
    if (rst) pend_q <= 1'b1;
    else     pend_q <= (pend_q & ~start) | hit;
  end

  AST_START_TAKEN: assert property (@(posedge clk) disable iff (rst)
    start |=> busy); // R7

endmodule

// File: rtl/crc8_scan.sv
module crc8_scan #(
  parameter int DEPTH = 128,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          busy,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  output logic          dv,
  output logic          dlast
);

  localparam logic [AW-1:0] TOP_ADDR = AW'(DEPTH - 1);

  logic          busy_q, iss_q, dv_q, dlast_q;
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      iss_q   <= 1'b0;
      addr_q  <= '0;
      dv_q    <= 1'b0;
      dlast_q <= 1'b0;
    end else begin
      dv_q    <= iss_q;
      dlast_q <= iss_q && (addr_q == TOP_ADDR);
      if (start) begin
        busy_q <= 1'b1;
        iss_q  <= 1'b1;
        addr_q <= '0;
      end else begin
        if (iss_q) begin
          addr_q <= addr_q + 1'b1;
          if (addr_q == TOP_ADDR) iss_q <= 1'b0;
        end
        if (dv_q && dlast_q) busy_q <= 1'b0;
      end
    end
  end

  assign busy    = busy_q;
  assign rd_en   = iss_q;
  assign rd_addr = addr_q;
  assign dv      = dv_q;
  assign dlast   = dlast_q;

  AST_RD_IN_SCAN: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> busy); // R4
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    (rd_en && $past(rd_en)) |-> (rd_addr == $past(rd_addr) + 1'b1)); // R4

endmodule

// File: rtl/crc8_accum.sv
module crc8_accum
  import crc8_chk_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       busy,
  input  logic       dv,
  input  logic       dlast,
  input  logic [7:0] rd_data,
  output logic       crc_ok,
  output logic [7:0] crc_value
);

  logic [7:0] run_q, res_q;
  logic       ok_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= CRC_SEED;
      res_q <= 8'h00;
      ok_q  <= 1'b0;
    end else if (start) begin
      run_q <= CRC_SEED;
      ok_q  <= 1'b0;
    end else if (dv) begin
      if (dlast) begin
        res_q <= run_q;
        ok_q  <= (run_q == rd_data);
      end else begin
        run_q <= crc8_fold(run_q, rd_data);
      end
    end
  end

  assign crc_ok    = ok_q;
  assign crc_value = res_q;

  AST_FOLD_IN_SCAN: assert property (@(posedge clk) disable iff (rst)
    dv |-> busy); // R4
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!busy && !$past(busy)) |-> $stable(crc_value)); // R8

endmodule

// File: rtl/crc8_mem_checker.sv
module crc8_mem_checker #(
  parameter int DEPTH = 128,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          prog_we,
  input  logic [AW-1:0] prog_addr,
  input  logic          calc_req,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  input  logic [7:0]    rd_data,
  output logic          busy,
  output logic          crc_ok,
  output logic [7:0]    crc_value
);

  logic start, dv, dlast;

  crc8_trig #(.DEPTH(DEPTH), .AW(AW)) i_trig (
    .clk(clk), .rst(rst), .busy(busy), .calc_req(calc_req),
    .prog_we(prog_we), .prog_addr(prog_addr), .start(start)
  );

  crc8_scan #(.DEPTH(DEPTH), .AW(AW)) i_scan (
    .clk(clk), .rst(rst), .start(start), .busy(busy),
    .rd_en(rd_en), .rd_addr(rd_addr), .dv(dv), .dlast(dlast)
  );

  crc8_accum i_accum (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .dv(dv),
    .dlast(dlast), .rd_data(rd_data), .crc_ok(crc_ok), .crc_value(crc_value)
  );

  AST_OK_LOW_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy |-> !crc_ok); // R8

endmodule

// File: tb/test_crc8_mem_checker.sv
module test_crc8_mem_checker;

  localparam int DEPTH = 32;
  localparam int AW    = $clog2(DEPTH);
  localparam int LAST  = DEPTH - 1;
  // {trigger by top-byte write, pattern, seed, corrupt stored checksum}
  localparam logic [11:0] VEC [6] = '{
    {1'b0, 2'd0, 8'h00, 1'b0},
    {1'b0, 2'd1, 8'h5A, 1'b1},
    {1'b1, 2'd2, 8'hC3, 1'b0},
    {1'b1, 2'd3, 8'hFF, 1'b1},
    {1'b0, 2'd3, 8'h81, 1'b0},
    {1'b1, 2'd1, 8'h00, 1'b1}
  };

  logic          clk = 1'b0, rst = 1'b1;
  logic          prog_we = 1'b0, calc_req = 1'b0;
  logic [AW-1:0] prog_addr = '0;
  logic          rd_en, busy, crc_ok;
  logic [AW-1:0] rd_addr;
  logic [7:0]    rd_q, crc_value;
  logic [7:0]    mem [DEPTH];
  int total = 0, bad = 0, n_reads = 0, n_mism = 0, exp_a = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  crc8_mem_checker #(.DEPTH(DEPTH)) i_crc8_mem_checker (
    .clk(clk), .rst(rst), .prog_we(prog_we), .prog_addr(prog_addr),
    .calc_req(calc_req), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_q),
    .busy(busy), .crc_ok(crc_ok), .crc_value(crc_value)
  );

  // Memory model with a one-cycle read, plus a read-order monitor
  always @(posedge clk) begin
    if (rd_en) begin
      rd_q <= mem[rd_addr];
      n_reads <= n_reads + 1;
      if (int'(rd_addr) != exp_a) n_mism <= n_mism + 1;
      exp_a <= (int'(rd_addr) == LAST) ? 0 : int'(rd_addr) + 1;
    end
  end

  task automatic chk(input bit good, input string req, input int act, input int exp);
    total++;
    if (!good) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_step(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] x = c ^ d;
    for (int b = 0; b < 8; b++) x = x[7] ? ((x << 1) ^ 8'h07) : (x << 1);
    return x;
  endfunction

  function automatic logic [7:0] pat_byte(input int p, input logic [7:0] s, input int i);
    case (p)
      0: return s;
      1: return s + 8'(i);
      2: return 8'(i * 7) ^ s ^ 8'(i >> 2);
      default: return i[0] ? ~s : s;
    endcase
  endfunction

  function automatic logic [7:0] ref_crc();
    logic [7:0] c = 8'hFF;
    for (int i = 0; i < LAST; i++) c = ref_step(c, mem[i]);
    return c;
  endfunction

  task automatic fill(input int p, input logic [7:0] s);
    for (int i = 0; i < LAST; i++) mem[i] = pat_byte(p, s, i);
  endtask

  // All drives happen at a falling edge and last one cycle
  task automatic prog_write(input int a, input logic [7:0] d);
    prog_we = 1'b1; prog_addr = AW'(a); mem[a] = d;
    @(negedge clk); prog_we = 1'b0;
  endtask

  task automatic pulse_req();
    calc_req = 1'b1;
    @(negedge clk); calc_req = 1'b0;
  endtask

  task automatic start_seen(input string req);
    chk(busy == 1'b0, req, busy, 0);   // trigger only latched at its edge
    @(negedge clk);
    chk(busy == 1'b1, req, busy, 1);
  endtask

  task automatic count_busy(output int n, output int ok_hi);
    n = 0; ok_hi = 0;
    while (busy && n < 4 * DEPTH) begin
      n++;
      if (crc_ok) ok_hi++;
      @(negedge clk);
    end
  endtask

  task automatic finish_scan(input logic [7:0] ec, input bit eok, input int r0, input int m0);
    int n, okh;
    count_busy(n, okh);
    chk(n == DEPTH + 1, "R4 busy length", n, DEPTH + 1);
    chk(okh == 0, "R8 ok low while busy", okh, 0);
    chk(n_reads - r0 == DEPTH, "R4 read count", n_reads - r0, DEPTH);
    chk(n_mism == m0, "R4 read order", n_mism - m0, 0);
    chk(crc_value == ec, "R2 crc value", crc_value, ec);
    chk(crc_ok == eok, "R3 ok flag", crc_ok, eok);
  endtask

  initial begin
    int r0, m0, n, okh;
    logic [7:0] ec, st, keep;
    fill(1, 8'h10);
    ec = ref_crc();
    mem[LAST] = ec;
    repeat (4) @(negedge clk);
    chk(!busy && !crc_ok && !rd_en, "R1 reset flags", {busy, crc_ok, rd_en}, 0);
    chk(crc_value == 8'h00, "R1 reset value", crc_value, 0);
    r0 = n_reads; m0 = n_mism;
    rst = 1'b0;
    @(negedge clk);
    chk(busy == 1'b1, "R1 start after reset", busy, 1);
    finish_scan(ec, 1'b1, r0, m0);

    // Vector table
    for (int v = 0; v < 6; v++) begin
      fill(int'(VEC[v][10:9]), VEC[v][8:1]);
      ec = ref_crc();
      st = VEC[v][0] ? (ec ^ 8'h3C) : ec;
      repeat (2) @(negedge clk);
      r0 = n_reads; m0 = n_mism;
      if (VEC[v][11]) begin
        prog_write(LAST, st);
        start_seen("R5 top-byte write start");
      end else begin
        mem[LAST] = st;
        pulse_req();
        start_seen("R6 request start");
      end
      finish_scan(ec, !VEC[v][0], r0, m0);
    end

    // Write to another address while idle: ignored (R5)
    keep = crc_value;
    prog_write(3, 8'hE7);
    for (int k = 0; k < 6; k++) begin
      chk(busy == 1'b0, "R5 other address ignored", busy, 0);
      @(negedge clk);
    end
    chk(crc_value == keep, "R8 value held", crc_value, keep);
    ec = ref_crc();
    mem[LAST] = ec;
    r0 = n_reads; m0 = n_mism;
    pulse_req();
    start_seen("R6 request start");
    finish_scan(ec, 1'b1, r0, m0);

    // Several triggers during a scan collapse into one rescan (R7)
    pulse_req();
    start_seen("R6 request start");
    repeat (3) @(negedge clk);
    pulse_req();
    repeat (4) @(negedge clk);
    prog_write(LAST, ec);
    pulse_req();
    count_busy(n, okh);
    chk(busy == 1'b0, "R7 one idle cycle", busy, 0);
    chk(crc_ok == 1'b1, "R3 ok after first scan", crc_ok, 1);
    r0 = n_reads; m0 = n_mism;
    @(negedge clk);
    chk(busy == 1'b1, "R7 rescan starts", busy, 1);
    finish_scan(ec, 1'b1, r0, m0);
    for (int k = 0; k < 6; k++) begin
      chk(busy == 1'b0, "R7 single rescan", busy, 0);
      @(negedge clk);
    end

    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule